// File: doc/BRIEF.md
# Paired-Page Address Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical address using a small fully associative table. Each table slot maps two neighbouring pages at once, an even page and an odd page, and carries its own page-size mask. The page size can grow from 4 KiB upward by powers of four. A lookup is offered for one cycle with the address, a load/store flag and the current address-space identifier (ASID). One cycle later the block returns either the translated address or an exception code.

Every slot is compared in parallel. A slot matches when its stored virtual page-pair number equals the address, ignoring the bits covered by its page mask, and its ASID equals the current one or its global flag is set. The address bit just above the page offset then picks the even or odd half. That half's valid and dirty flags decide whether the access succeeds. A missing match, a cleared valid flag, or a store to a clean page each give a distinct exception. When any exception is raised, the block records the faulting address, a page-pair/ASID word for the refill handler, and a pseudo-random slot number for replacement that never falls below the count of protected ("wired") slots.

Slots are loaded through a single write port, one slot per cycle.

Top module: `paired_tlb`

## Requirements
- R1: After reset, rsp_valid is 0, rsp_exc is 0, and bad_va, fault_hi and repl_idx are all 0. A slot that has never been written never matches, so a lookup right after reset returns a refill exception.
- R2: A slot matches when req_va[31:13] equals its page-pair number on every bit its page mask does not cover, and its ASID equals cur_asid. On a match with the selected half valid, rsp_pa equals the half's frame number shifted left by 12, with the offset bits replaced by req_va's offset bits, and rsp_exc is 0.
- R3: A slot whose global flag is set matches regardless of cur_asid.
- R4: The page mask m (12 bits) sets the offset to {m,12'hFFF}. The address bit just above the offset picks the even half when it is 0 and the odd half when it is 1. A 4 KiB page uses m=0 (select bit 12); a 16 KiB page uses m=3 (select bit 14, and bits 14:13 are ignored in the compare).
- R5: A match whose selected half has its valid flag cleared returns rsp_exc 3 for a load and 4 for a store.
- R6: A store that matches a valid half whose dirty flag is cleared returns rsp_exc 5. A load to the same half succeeds, and a store to a dirty half succeeds.
- R7: When no slot matches, rsp_exc is 1 for a load and 2 for a store.
- R8: On every exception, bad_va takes req_va and fault_hi takes {req_va[31:13], 5'b0, cur_asid}. Neither changes on a response without an exception.
- R9: On every exception, repl_idx takes a value in [wired, N_ENTRIES); if wired is at or above N_ENTRIES, the value is N_ENTRIES-1. repl_idx does not change on a response without an exception.
- R10: When several slots match, the lowest-numbered slot supplies the translation.
- R11: rsp_valid is 1 exactly one cycle after a cycle with req_valid 1. In a cycle after no request, rsp_valid and rsp_exc are 0.
- R12: A slot written through the write port is used by a lookup presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one slot this cycle |
| wr_idx | input | IDX_W | Slot number to write |
| wr_vpn2 | input | 19 | Virtual page-pair number (address bits 31:13) |
| wr_asid | input | 8 | Slot ASID |
| wr_global | input | 1 | Slot matches any ASID |
| wr_pmask | input | 12 | Page-size mask (low-aligned run of ones) |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_valid_even | input | 1 | Even page valid |
| wr_dirty_even | input | 1 | Even page writable |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_valid_odd | input | 1 | Odd page valid |
| wr_dirty_odd | input | 1 | Odd page writable |
| cur_asid | input | 8 | Current address-space identifier |
| wired | input | IDX_W | Slots below this are never chosen for replacement |
| req_valid | input | 1 | Lookup request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_va | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_exc | output | 3 | 0 none, 1 refill load, 2 refill store, 3 invalid load, 4 invalid store, 5 modify |
| rsp_pa | output | 32 | Physical address (0 on exception) |
| bad_va | output | 32 | Last faulting virtual address |
| fault_hi | output | 32 | Last faulting page-pair number and ASID |
| repl_idx | output | IDX_W | Suggested slot for the next refill |

## Verification
The hardest case to reach from the ports is two slots matching the same address, since normal refill software never builds that. The bench loads two slots with the same page pair and ASID but different frames, and checks that the lower slot's frame appears. A second hard case is the page-size path, which needs a large mask so the even/odd select bit and the ignored compare bits move upward. A global 16 KiB slot is probed at addresses that differ only in bits 13 and 14, under an unrelated ASID. The replacement range is driven to its edge by raising wired to one below the table size before a miss.

// File: rtl/ptlb_pkg.sv
// Shared constants and types for the paired-page translation buffer.
// Assumes a 32-bit virtual address, 4 KiB minimum page and 8-bit ASID.
package ptlb_pkg;
    localparam int VA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int PMASK_W = 12;
    localparam int PAIR_LSB = 13;
    localparam int VPN2_W  = VA_W - PAIR_LSB;
    localparam int PFN_W   = 20;
    localparam int PAGE_LSB = 12;

    typedef enum logic [2:0] {
        EXC_NONE      = 3'd0,
        EXC_REFILL_LD = 3'd1,
        EXC_REFILL_ST = 3'd2,
        EXC_INVAL_LD  = 3'd3,
        EXC_INVAL_ST  = 3'd4,
        EXC_MODIFY    = 3'd5
    } tlb_exc_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             valid;
        logic             dirty;
    } tlb_half_t;

    typedef struct packed {
        logic               present;
        logic [VPN2_W-1:0]  vpn2;
        logic [ASID_W-1:0]  asid;
        logic               global_map;
        logic [PMASK_W-1:0] pmask;
        tlb_half_t          even;
        tlb_half_t          odd;
    } tlb_slot_t;
endpackage

// File: rtl/ptlb_store.sv
// Slot storage: N_ENTRIES registers written one per cycle.
// Assumes the writer keeps page masks as a low-aligned run of ones.
module ptlb_store
    import ptlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_slot_t        wr_slot,
    output tlb_slot_t        slots [N_ENTRIES]
);
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        // Hold one slot; reset clears its present flag so it cannot match.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                slots[g] <= wr_slot;
        end
    end
endmodule

// File: rtl/ptlb_match.sv
// Parallel compare of one address against all slots, half select and
// physical address forming; lowest-numbered matching slot wins.
// Purely combinational.
module ptlb_match
    import ptlb_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    input  tlb_slot_t         slots [N_ENTRIES],
    output logic              hit_any,
    output tlb_half_t         sel_half,
    output logic [VA_W-1:0]   sel_pa
);
    logic [N_ENTRIES-1:0] hit_vec;
    tlb_half_t            half_vec [N_ENTRIES];
    logic [VA_W-1:0]      pa_vec   [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        logic [VA_W-1:0]   off_mask;
        logic [VA_W-1:0]   sel_bit;
        logic [VPN2_W-1:0] cmp_mask;
        logic              odd;

        // Per-slot masks, match test and half selection.
        always_comb begin
            off_mask = {{(VA_W-PMASK_W-PAGE_LSB){1'b0}}, slots[g].pmask,
                        {PAGE_LSB{1'b1}}};
            sel_bit  = off_mask + VA_W'(1);
            cmp_mask = ~{{(VPN2_W-PMASK_W){1'b0}}, slots[g].pmask};
            odd      = |(va & sel_bit);
            hit_vec[g] = slots[g].present
                      && (((va[VA_W-1:PAIR_LSB] ^ slots[g].vpn2) & cmp_mask) == '0)
                      && (slots[g].global_map || slots[g].asid == asid);
            half_vec[g] = odd ? slots[g].odd : slots[g].even;
            pa_vec[g]   = ({half_vec[g].pfn, {PAGE_LSB{1'b0}}} & ~off_mask)
                        | (va & off_mask);
        end
    end

    // Priority pick: scan downward so the lowest matching slot is kept.
    always_comb begin
        hit_any  = 1'b0;
        sel_half = '0;
        sel_pa   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any  = 1'b1;
                sel_half = half_vec[i];
                sel_pa   = pa_vec[i];
            end
        end
    end
endmodule

// File: rtl/ptlb_repl.sv
// Replacement slot picker: a free-running 16-bit LFSR folded into
// [wired, N_ENTRIES). Assumes N_ENTRIES <= 65536.
module ptlb_repl #(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES),
    localparam int LFSR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] wired,
    output logic [IDX_W-1:0] pick
);
    logic [LFSR_W-1:0] lfsr;
    logic [IDX_W:0]    floor_c;
    logic [IDX_W:0]    span;
    logic [LFSR_W-1:0] folded;

    // Advance the Galois LFSR every cycle; never reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr <= LFSR_W'(1);
        else
            lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    end

    // Clamp the floor below the table size and fold the LFSR into the span.
    always_comb begin
        floor_c = ({1'b0, wired} >= (IDX_W+1)'(N_ENTRIES))
                ? (IDX_W+1)'(N_ENTRIES - 1) : {1'b0, wired};
        span    = (IDX_W+1)'(N_ENTRIES) - floor_c;
        folded  = lfsr % LFSR_W'(span);
        pick    = IDX_W'(floor_c + (IDX_W+1)'(folded));
    end
endmodule

// File: rtl/paired_tlb.sv
// Paired-page translation buffer top: registers one lookup response per
// request, classifies faults and captures fault state for the refill path.
// Assumes at most one request per cycle and a write not aimed at a slot
// being looked up in the same cycle (the lookup then sees the old slot).
module paired_tlb
    import ptlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [18:0]         wr_vpn2,
    input  logic [7:0]          wr_asid,
    input  logic                wr_global,
    input  logic [11:0]         wr_pmask,
    input  logic [19:0]         wr_pfn_even,
    input  logic                wr_valid_even,
    input  logic                wr_dirty_even,
    input  logic [19:0]         wr_pfn_odd,
    input  logic                wr_valid_odd,
    input  logic                wr_dirty_odd,
    input  logic [7:0]          cur_asid,
    input  logic [IDX_W-1:0]    wired,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [31:0]         req_va,
    output logic                rsp_valid,
    output logic [2:0]          rsp_exc,
    output logic [31:0]         rsp_pa,
    output logic [31:0]         bad_va,
    output logic [31:0]         fault_hi,
    output logic [IDX_W-1:0]    repl_idx
);
    tlb_slot_t       wr_slot;
    tlb_slot_t       slots [N_ENTRIES];
    logic            hit_any;
    tlb_half_t       sel_half;
    logic [VA_W-1:0] sel_pa;
    logic [IDX_W-1:0] pick;
    tlb_exc_e        exc_next;

    // Gather the flat write-port fields into one slot record.
    always_comb begin
        wr_slot.present    = 1'b1;
        wr_slot.vpn2       = wr_vpn2;
        wr_slot.asid       = wr_asid;
        wr_slot.global_map = wr_global;
        wr_slot.pmask      = wr_pmask;
        wr_slot.even       = '{pfn: wr_pfn_even, valid: wr_valid_even, dirty: wr_dirty_even};
        wr_slot.odd        = '{pfn: wr_pfn_odd,  valid: wr_valid_odd,  dirty: wr_dirty_odd};
    end

    ptlb_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_slot(wr_slot), .slots(slots)
    );

    ptlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .va(req_va), .asid(cur_asid), .slots(slots),
        .hit_any(hit_any), .sel_half(sel_half), .sel_pa(sel_pa)
    );

    ptlb_repl #(.N_ENTRIES(N_ENTRIES)) u_repl (
        .clk(clk), .rst_n(rst_n), .wired(wired), .pick(pick)
    );

    // Classify the lookup: miss, then invalid half, then clean-page store.
    always_comb begin
        if (!hit_any)
            exc_next = req_store ? EXC_REFILL_ST : EXC_REFILL_LD;
        else if (!sel_half.valid)
            exc_next = req_store ? EXC_INVAL_ST : EXC_INVAL_LD;
        else if (req_store && !sel_half.dirty)
            exc_next = EXC_MODIFY;
        else
            exc_next = EXC_NONE;
    end

    // Register the response for one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_exc   <= EXC_NONE;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_exc   <= req_valid ? exc_next : EXC_NONE;
            rsp_pa    <= (req_valid && exc_next == EXC_NONE) ? sel_pa : '0;
        end
    end

    // Capture fault state and a replacement slot on every exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_va   <= '0;
            fault_hi <= '0;
            repl_idx <= '0;
        end else if (req_valid && exc_next != EXC_NONE) begin
            bad_va   <= req_va;
            fault_hi <= {req_va[VA_W-1:PAIR_LSB], {(PAIR_LSB-ASID_W){1'b0}}, cur_asid};
            repl_idx <= pick;
        end
    end

    // R11: a response follows each request by exactly one cycle.
    a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_exc == 3'(EXC_NONE)));
    // R6: a modify fault only ever answers a store.
    a_r6_modify_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc == 3'(EXC_MODIFY) |-> $past(req_store));
    // R7: refill kind follows the request direction.
    a_r7_refill_store_kind: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc == 3'(EXC_REFILL_ST) |-> $past(req_store));
    // R8: fault capture holds across responses without an exception.
    a_r8_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc == 3'(EXC_NONE) |-> ($stable(bad_va) && $stable(fault_hi) && $stable(repl_idx)));
    // R9: a new replacement slot respects the wired floor.
    a_r9_repl_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc != 3'(EXC_NONE) && $past(wired) < IDX_W'(N_ENTRIES - 1))
        |-> repl_idx >= $past(wired));
endmodule

// File: tb/paired_tlb_bench.sv
module paired_tlb_bench;
    localparam int N = 16;
    localparam int IW = $clog2(N);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [11:0] wr_pmask = '0;
    logic [19:0] wr_pfn_even = '0;
    logic        wr_valid_even = 1'b0;
    logic        wr_dirty_even = 1'b0;
    logic [19:0] wr_pfn_odd = '0;
    logic        wr_valid_odd = 1'b0;
    logic        wr_dirty_odd = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic [IW-1:0] wired = '0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_exc;
    logic [31:0] rsp_pa;
    logic [31:0] bad_va;
    logic [31:0] fault_hi;
    logic [IW-1:0] repl_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    paired_tlb #(.N_ENTRIES(N)) u_paired_tlb (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_slot(input int idx, input logic [18:0] vpn2, input logic [7:0] asid,
                            input logic g, input logic [11:0] pm,
                            input logic [19:0] pe, input logic ve, input logic de,
                            input logic [19:0] po, input logic vo, input logic dd);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_vpn2 = vpn2; wr_asid = asid; wr_global = g;
        wr_pmask = pm; wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
        wr_pfn_odd = po; wr_valid_odd = vo; wr_dirty_odd = dd;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Present one request; on return the registered response is stable.
    task automatic look(input logic [31:0] va, input logic st, input logic [7:0] asid);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_store = st; cur_asid = asid;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 rsp_exc", 32'(rsp_exc), 0);
        chk("R1 bad_va", bad_va, 0);
        chk("R1 fault_hi", fault_hi, 0);
        chk("R1 repl_idx", 32'(repl_idx), 0);
        look(32'h0000_0ABC, 1'b0, 8'h00);
        chk("R1 unwritten slot misses", 32'(rsp_exc), 1);
    endtask

    task automatic t_small_pages;
        put_slot(0, 19'h00200, 8'h05, 1'b0, 12'h000, 20'h12345, 1, 1, 20'h0ABCD, 1, 0);
        look(32'h0040_0123, 1'b0, 8'h05);
        chk("R12 R2 even hit exc", 32'(rsp_exc), 0);
        chk("R2 even pa", rsp_pa, 32'h1234_5123);
        chk("R11 rsp_valid after req", 32'(rsp_valid), 1);
        look(32'h0040_1456, 1'b0, 8'h05);
        chk("R4 odd half pa", rsp_pa, 32'h0ABC_D456);
        chk("R6 load to clean page ok", 32'(rsp_exc), 0);
    endtask

    task automatic t_dirty;
        look(32'h0040_1456, 1'b1, 8'h05);
        chk("R6 store to clean page", 32'(rsp_exc), 5);
        chk("R8 bad_va on modify", bad_va, 32'h0040_1456);
        chk("R8 fault_hi on modify", fault_hi, 32'h0040_0005);
        look(32'h0040_0010, 1'b1, 8'h05);
        chk("R6 store to dirty page", 32'(rsp_exc), 0);
        chk("R6 store pa", rsp_pa, 32'h1234_5010);
        chk("R8 bad_va held after hit", bad_va, 32'h0040_1456);
    endtask

    task automatic t_asid_miss;
        look(32'h0040_0010, 1'b0, 8'h06);
        chk("R7 other asid refill load", 32'(rsp_exc), 1);
        chk("R8 bad_va refill", bad_va, 32'h0040_0010);
        chk("R8 fault_hi refill", fault_hi, 32'h0040_0006);
    endtask

    task automatic t_big_global;
        put_slot(1, 19'h08000, 8'h09, 1'b1, 12'h003, 20'h20007, 1, 1, 20'h30000, 0, 0);
        look(32'h1000_2ABC, 1'b0, 8'h33);
        chk("R3 global hit", 32'(rsp_exc), 0);
        chk("R4 16K even pa", rsp_pa, 32'h2000_6ABC);
        look(32'h1000_4000, 1'b1, 8'h33);
        chk("R5 invalid store", 32'(rsp_exc), 4);
        chk("R8 fault_hi invalid", fault_hi, 32'h1000_4033);
        look(32'h1000_4000, 1'b0, 8'h33);
        chk("R5 invalid load", 32'(rsp_exc), 3);
    endtask

    task automatic t_overlap;
        put_slot(3, 19'h10000, 8'h07, 1'b0, 12'h000, 20'h00222, 1, 1, 20'h0, 0, 0);
        put_slot(2, 19'h10000, 8'h07, 1'b0, 12'h000, 20'h00111, 1, 1, 20'h0, 0, 0);
        look(32'h2000_0010, 1'b0, 8'h07);
        chk("R10 lowest slot wins", rsp_pa, 32'h0011_1010);
    endtask

    task automatic t_refill_store;
        look(32'h7000_1234, 1'b1, 8'h44);
        chk("R7 refill store", 32'(rsp_exc), 2);
        chk("R8 bad_va refill store", bad_va, 32'h7000_1234);
        chk("R8 fault_hi refill store", fault_hi, 32'h7000_0044);
    endtask

    task automatic t_repl;
        logic [IW-1:0] held;
        wired = IW'(4);
        for (int k = 0; k < 6; k++) begin
            repeat (k + 1) @(negedge clk);
            look(32'h7000_0000, 1'b0, 8'h01);
            checks++;
            if (repl_idx < IW'(4)) begin
                errors++;
                $display("FAIL R9 repl below wired actual=%0d expected>=4", repl_idx);
            end
        end
        wired = IW'(15);
        look(32'h7000_0000, 1'b0, 8'h01);
        chk("R9 repl at top floor", 32'(repl_idx), 15);
        wired = IW'(4);
        held = repl_idx;
        look(32'h0040_0123, 1'b0, 8'h05);
        chk("R9 repl held on hit", 32'(repl_idx), 32'(held));
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        chk("R11 idle rsp_valid", 32'(rsp_valid), 0);
        chk("R11 idle rsp_exc", 32'(rsp_exc), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_small_pages;
        t_dirty;
        t_asid_miss;
        t_big_global;
        t_overlap;
        t_refill_store;
        t_repl;
        t_idle;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule